// File: doc/BRIEF.md
# Fiber Transmit Squelch and Idle Tone Generator

This block stands between the sampled transmit pair coming from the attachment interface and the bit that keys the optical emitter. Each clock, the block receives two bits for the pair. One is a polarity bit that is high when the pair is driven negative, which is the light-on sense. The other is a level bit that is high when the swing is large enough to count. From these the block decides whether the activity is a real packet or noise. Valid packet data goes through to the optical output. When the pair stays quiet long enough, the block recognises the start of idle. Whenever no packet is being sent, the optical output carries a square idle tone that runs all the time.

All logic runs on one sample clock. Each timing is a parameter counted in samples. At 100 MHz the defaults give a 20 ns noise floor, a 180 ns idle gap and a 1 MHz tone. Two disable inputs, one from the jabber logic and one from the low-light monitor, stop data from reaching the output. The tone keeps running on the output while either is asserted. A transmit-active flag tells the collision, quality-test and jabber logic when a packet is in progress.

Top module: `fo_tx_squelch`

## Requirements
- R1: A synchronous reset clears `opt_data` and `tx_active` to 0. After reset ends, the tone begins in its low phase.
- R2: When nothing is being sent, `opt_data` follows the tone. The tone is low for the first TONE_HALF edges after reset and high for the next TONE_HALF edges, with a period of 2*TONE_HALF edges. It keeps running through packets.
- R3: A run of qualified samples shorter than MIN_PULSE does not set `tx_active`. The output stays on the tone.
- R4: A sample with `do_neg`=1 and `do_lvl_ok`=0 is unqualified. It cannot start a packet, however long it lasts.
- R5: `tx_active` rises on the edge that samples the MIN_PULSE-th consecutive qualified sample. Only the first MIN_PULSE-1 samples are lost.
- R6: While `tx_active` is set and neither disable is high, each edge loads `opt_data` with the qualified value (`do_neg` AND `do_lvl_ok`) sampled at that edge.
- R7: `tx_active` falls on the edge that samples the (IDLE_GAP+1)-th consecutive unqualified sample, and `opt_data` returns to the tone on that same edge. A shorter gap keeps `tx_active` set.
- R8: While `jab_dis` or `lowlight_dis` is 1, `opt_data` carries the tone. `tx_active` still follows the squelch state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| do_neg | input | 1 | Transmit pair polarity, 1 = negative (light on) |
| do_lvl_ok | input | 1 | Swing exceeds the squelch level |
| jab_dis | input | 1 | Jabber disable of data transmission |
| lowlight_dis | input | 1 | Low-light disable of data transmission |
| opt_data | output | 1 | Bit that keys the optical emitter |
| tx_active | output | 1 | Packet in progress, from unsquelch to start of idle |

## Verification
Both outputs are registered. Every result therefore appears one edge after the sample that causes it. Unsquelch shows on the edge of the second qualified sample, data follows with one cycle of latency, and resquelch shows on the edge of the nineteenth quiet sample. The driver sets the inputs on the falling edge and queues the outputs that the requirements predict for the next rising edge. The monitor pops and compares them 1 ns after that edge. This keeps every comparison on the cycle in which the result is due. The tone is predicted from a count of edges since reset, kept apart from the design's own counter.

// File: rtl/fo_tx_pkg.sv
package fo_tx_pkg;
  // width for a counter that must hold values 0..maxv
  function automatic int cnt_bits(input int maxv);
    return (maxv < 2) ? 1 : $clog2(maxv + 1);
  endfunction

  // tone is high in the second half of its period
  function automatic logic tone_level(input int unsigned pos, input int unsigned half);
    return (pos >= half);
  endfunction

  // wrap a phase counter at the end of the period
  function automatic int unsigned tone_step(input int unsigned pos, input int unsigned half);
    return (pos >= 2 * half - 1) ? 0 : pos + 1;
  endfunction
endpackage

// File: rtl/fo_tx_tone.sv
module fo_tx_tone import fo_tx_pkg::*; #(
  parameter int TONE_HALF = 50
) (
  input  logic clk,
  input  logic rst,
  output logic tone
);
  localparam int PW = cnt_bits(2 * TONE_HALF - 1);

  logic [PW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst) phase_q <= '0;
    else     phase_q <= PW'(tone_step(int'(phase_q), TONE_HALF));
  end

  assign tone = tone_level(int'(phase_q), TONE_HALF);

  AST_TONE_RANGE: assert property (@(posedge clk) disable iff (rst)
    int'(phase_q) < 2 * TONE_HALF); // R2
  AST_TONE_RISE: assert property (@(posedge clk) disable iff (rst)
    (int'(phase_q) == TONE_HALF - 1) |=> tone); // R2
  AST_TONE_FALL: assert property (@(posedge clk) disable iff (rst)
    (int'(phase_q) == 2 * TONE_HALF - 1) |=> !tone); // R2
endmodule

// File: rtl/fo_tx_sqfsm.sv
module fo_tx_sqfsm import fo_tx_pkg::*; #(
  parameter int MIN_PULSE = 2,
  parameter int IDLE_GAP  = 18
) (
  input  logic clk,
  input  logic rst,
  input  logic qual,
  output logic active_d,
  output logic active_q
);
  localparam int LIM = (MIN_PULSE > IDLE_GAP + 1) ? MIN_PULSE : IDLE_GAP + 1;
  localparam int CW  = cnt_bits(LIM);

  logic [CW-1:0] run_q;
  logic [CW-1:0] run_d;
  logic          unsq_ev;   // qualified run long enough
  logic          soi_ev;    // start of idle seen

  assign unsq_ev = !active_q && qual && (int'(run_q) >= MIN_PULSE - 1);
  assign soi_ev  =  active_q && !qual && (int'(run_q) >= IDLE_GAP);

  always_comb begin
    active_d = active_q;
    run_d    = run_q;
    if (unsq_ev) begin
      active_d = 1'b1;
      run_d    = '0;
    end else if (soi_ev) begin
      active_d = 1'b0;
      run_d    = '0;
    end else if (active_q) begin
      run_d = qual ? '0 : run_q + 1'b1;
    end else begin
      run_d = qual ? run_q + 1'b1 : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      run_q    <= '0;
    end else begin
      active_q <= active_d;
      run_q    <= run_d;
    end
  end

  AST_NO_UNSQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!active_q && !qual) |=> !active_q); // R3
  AST_RISE_ON_QUAL: assert property (@(posedge clk) disable iff (rst)
    $rose(active_q) |-> $past(qual)); // R5
  AST_HOLD_ON_QUAL: assert property (@(posedge clk) disable iff (rst)
    (active_q && qual) |=> active_q); // R7
  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (rst)
    int'(run_q) <= LIM); // R7
endmodule

// File: rtl/fo_tx_squelch.sv
module fo_tx_squelch import fo_tx_pkg::*; #(
  parameter int MIN_PULSE = 2,
  parameter int IDLE_GAP  = 18,
  parameter int TONE_HALF = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic do_neg,
  input  logic do_lvl_ok,
  input  logic jab_dis,
  input  logic lowlight_dis,
  output logic opt_data,
  output logic tx_active
);
  logic qual;
  logic tone;
  logic active_d;
  logic send_d;
  logic data_dis;

  assign qual     = do_neg & do_lvl_ok;
  assign data_dis = jab_dis | lowlight_dis;

  fo_tx_sqfsm #(.MIN_PULSE(MIN_PULSE), .IDLE_GAP(IDLE_GAP)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .qual     (qual),
    .active_d (active_d),
    .active_q (tx_active)
  );

  fo_tx_tone #(.TONE_HALF(TONE_HALF)) u_tone (
    .clk  (clk),
    .rst  (rst),
    .tone (tone)
  );

  assign send_d = active_d & ~data_dis;

  always_ff @(posedge clk) begin
    if (rst)         opt_data <= 1'b0;
    else if (send_d) opt_data <= qual;
    else             opt_data <= tone;
  end

  AST_RESET_DARK: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!opt_data && !tx_active)); // R1
  AST_IDLE_TONE: assert property (@(posedge clk) disable iff (rst)
    (!tx_active && !qual) |=> (opt_data == $past(tone))); // R2
  AST_DIS_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    (data_dis && tx_active && qual && !tone) |=> !opt_data); // R8
endmodule

// File: tb/fo_tx_squelch_tb.sv
module fo_tx_squelch_tb;
  localparam int MINP = 2;
  localparam int GAP  = 18;
  localparam int HALF = 50;

  typedef struct {
    logic  opt;
    logic  act;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic do_neg = 1'b0, do_lvl_ok = 1'b0, jab_dis = 1'b0, lowlight_dis = 1'b0;
  logic opt_data, tx_active;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  exp_t sb[$];

  // reference state, kept from requirement wording
  int  edges = 0;      // edges since reset released
  int  qrun  = 0;      // consecutive qualified samples while squelched
  int  gap   = 0;      // consecutive unqualified samples while sending
  bit  in_pkt = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  fo_tx_squelch #(.MIN_PULSE(MINP), .IDLE_GAP(GAP), .TONE_HALF(HALF)) u_dut (
    .clk(clk), .rst(rst), .do_neg(do_neg), .do_lvl_ok(do_lvl_ok),
    .jab_dis(jab_dis), .lowlight_dis(lowlight_dis),
    .opt_data(opt_data), .tx_active(tx_active)
  );

  function automatic logic tone_at(input int e);
    // edge e (1 = first after reset) shows low for HALF edges, then high
    return (((e - 1) % (2 * HALF)) >= HALF);
  endfunction

  task automatic drv(input logic n, input logic l, input logic jd, input logic ld, input string tag);
    exp_t it;
    bit   q;
    @(negedge clk);
    do_neg = n; do_lvl_ok = l; jab_dis = jd; lowlight_dis = ld;
    q = n && l;
    edges++;
    if (!in_pkt) begin
      qrun = q ? qrun + 1 : 0;
      if (qrun >= MINP) begin in_pkt = 1'b1; gap = 0; end
    end else begin
      gap = q ? 0 : gap + 1;
      if (gap > GAP) begin in_pkt = 1'b0; qrun = 0; end
    end
    it.act = in_pkt;
    it.opt = (in_pkt && !jd && !ld) ? q : tone_at(edges);
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic do_reset(input int cyc);
    exp_t it;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      rst = 1'b1; do_neg = 1'b0; do_lvl_ok = 1'b0; jab_dis = 1'b0; lowlight_dis = 1'b0;
      edges = 0; qrun = 0; gap = 0; in_pkt = 1'b0;
      it.opt = 1'b0; it.act = 1'b0; it.tag = "R1";
      sb.push_back(it);
    end
    @(negedge clk);
    rst = 1'b0;
    // the edge after this negedge has rst low: tone position 0 (low)
    edges++;
    it.opt = tone_at(edges); it.act = 1'b0; it.tag = "R1";
    sb.push_back(it);
  endtask

  // monitor: one expectation per rising edge, compared 1 ns after it
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (opt_data !== e.opt || tx_active !== e.act) begin
          fails++;
          $display("FAIL %s: opt_data=%b tx_active=%b expected opt_data=%b tx_active=%b at %0t",
                   e.tag, opt_data, tx_active, e.opt, e.act, $time);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset(3);                                   // R1
    for (int i = 0; i < 230; i++) drv(0, 0, 0, 0, "R2");  // full tone periods
    // R3: isolated one-sample qualified pulses
    for (int k = 0; k < 4; k++) begin
      drv(1, 1, 0, 0, "R3");
      for (int i = 0; i < 6; i++) drv(0, 1, 0, 0, "R3");
    end
    // R4: long negative swing below the level threshold
    for (int i = 0; i < 40; i++) drv(1, 0, 0, 0, "R4");
    drv(0, 0, 0, 0, "R4");
    // R5 + R6: a Manchester-like packet, 5 samples per half bit
    for (int b = 0; b < 24; b++) begin
      for (int i = 0; i < 5; i++) drv(1, 1, 0, 0, (b == 0) ? "R5" : "R6");
      for (int i = 0; i < 5; i++) drv(b[0], 1, 0, 0, "R6");
    end
    // R7: a gap of exactly IDLE_GAP keeps the packet alive
    for (int i = 0; i < GAP; i++) drv(0, 1, 0, 0, "R7");
    drv(1, 1, 0, 0, "R7");
    // R7: gap of IDLE_GAP+1 ends the packet, output returns to tone
    for (int i = 0; i < GAP + 6; i++) drv(0, 0, 0, 0, "R7");
    // R8: jabber disable during a packet
    for (int b = 0; b < 8; b++) begin
      for (int i = 0; i < 5; i++) drv(1, 1, 1, 0, "R8");
      for (int i = 0; i < 5; i++) drv(0, 1, 1, 0, "R8");
    end
    // R8: low-light disable toggling in mid packet
    for (int b = 0; b < 8; b++) begin
      for (int i = 0; i < 5; i++) drv(1, 1, 0, b[1], "R8");
      for (int i = 0; i < 5; i++) drv(0, 1, 0, b[1], "R8");
    end
    for (int i = 0; i < 60; i++) drv(0, 0, 0, 0, "R7");
    // R1: reset in mid packet
    for (int i = 0; i < 6; i++) drv(1, 1, 0, 0, "R5");
    do_reset(2);
    for (int i = 0; i < 120; i++) drv(0, 0, 0, 0, "R1");
    @(posedge clk);
    #2;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule